// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the transmit half of a small Ethernet MAC, seen by software as a 32-bit register and memory window. It holds two frame buffers that software uses in alternation. Software copies a frame into one buffer one word at a time, writes the byte count, and then sets the start bits in that buffer's status word. The block sends the bytes out on a byte-wide valid/ready stream. When the last byte has gone it clears the buffer's busy flag and can raise an interrupt. While one buffer is on the wire, software can fill and start the other. Started buffers are served strictly in the order they were started.

A second command reuses the same buffer path to set the station address. Instead of sending the buffer, the block loads the first six bytes of the buffer into its address register. The busy/active pair gives software a completion handshake without a FIFO. Busy is owned by hardware. Active keeps whatever software last wrote to it, so a completed buffer reads as active with busy clear.

Top module: `txpp_top`

## Requirements
- R1: After reset, every status word reads 0, the global enable reads 0, `tx_valid_o` and `irq_o` are low and `mac_addr_o` is 0.
- R2: Buffer b occupies byte offsets b*0x800 to b*0x800+0x7FF. Data words sit at offsets below 0x7F4, the 16-bit length sits at 0x7F4 and the status word sits at 0x7FC. The global enable is bit 31 at 0x7F8 and is reachable from either window. A read returns its data in the cycle after the address is presented.
- R3: Writing a status word with bit 0 = 1 and bit 1 = 0 while busy is clear starts a send. The buffer's bytes go out lowest address first, with byte 0 in bits 7:0 of word 0. A byte transfers on every cycle in which `tx_valid_o` and `tx_ready_i` are both high, and `tx_last_o` marks the final byte.
- R4: Status bit 0 (busy) reads 1 from the start write until the clock edge at which the last byte transfers, and then reads 0. Bit 31 (active) holds the value software last wrote to it, including after completion.
- R5: Writing bits 0 and 1 together while busy is clear loads buffer bytes 0..5 into `mac_addr_o`, with byte 0 in bits 47:40. No bytes appear on the stream, and bits 0 and 1 both clear when the load is done.
- R6: `irq_o` is high for exactly one cycle, starting at the edge where a buffer's busy falls. This happens only when the global enable and that buffer's bit 3 are both set.
- R7: When both buffers have been started, the buffer that was started first is served first.
- R8: While a buffer is busy, writes to its data words and its length are ignored, and so are writes to its bits 0 and 1. Writes to bits 3 and 31 still take effect.
- R9: A length above 1514 sends exactly 1514 bytes. A length of 0 sends no bytes but still completes: busy clears and the interrupt rule still applies.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, the next cycle keeps `tx_valid_o` high with `txd_o` and `tx_last_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 10 | Word address (byte address bits 11:2) |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the address |
| txd_o | output | 8 | Transmit byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Sink accepts the byte |
| mac_addr_o | output | 48 | Station address register |
| irq_o | output | 1 | Transmit-done interrupt pulse |

## Verification
The assertions assume the following about the inputs:
- Software never issues a start command to a buffer whose busy bit is already set.
- The sink may hold `tx_ready_i` low for any length of time, and the design is expected to stall cleanly when it does.

The stimulus stays within these assumptions. Each new command is written only to a buffer that the bench's own bookkeeping shows as free, or to a buffer that a status poll has just shown to be idle. The deliberate writes to a busy buffer are made only as part of the check that those writes are ignored. Ready is driven in three patterns: held high, held low to build up a two-deep backlog, and toggled from a pseudo-random sequence.

// File: rtl/txpp_pkg.sv
package txpp_pkg;
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_LOAD, S_ZERO} seq_state_e;
  localparam int unsigned ST_BUSY   = 0;
  localparam int unsigned ST_PROG   = 1;
  localparam int unsigned ST_IE     = 3;
  localparam int unsigned ST_ACT    = 31;
  localparam int unsigned MAC_BYTES = 6;
  localparam int unsigned MAX_BUF   = 2;
endpackage

// File: rtl/txpp_bank.sv
module txpp_bank import txpp_pkg::*; #(
  parameter int unsigned WIN_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WIN_AW-3:0] word_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [WIN_AW-1:0] byte_idx_i,
  output logic [7:0]        byte_o,
  input  logic              done_i,
  output logic              start_o,
  output logic              load_o,
  output logic              busy_o,
  output logic              ie_o,
  output logic [15:0]       len_o
);
  localparam int unsigned WORD_AW = WIN_AW - 2;
  localparam logic [WORD_AW-1:0] STAT_W = {WORD_AW{1'b1}};
  localparam logic [WORD_AW-1:0] LEN_W  = STAT_W - WORD_AW'(2);
  localparam int unsigned DATA_WORDS = (1 << WORD_AW) - 3;

  logic [31:0] mem [DATA_WORDS];
  logic        busy_q, prog_q, ie_q, act_q;
  logic [15:0] len_q;
  logic        is_data, is_len, is_stat;
  logic [31:0] rd_word;

  assign is_data = word_i < LEN_W;
  assign is_len  = word_i == LEN_W;
  assign is_stat = word_i == STAT_W;
  assign start_o = wr_i && is_stat && !busy_q && wdata_i[ST_BUSY];
  assign load_o  = start_o && wdata_i[ST_PROG];

  always_ff @(posedge clk_i) begin
    if (wr_i && is_data && !busy_q) mem[word_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      prog_q <= 1'b0;
      ie_q   <= 1'b0;
      act_q  <= 1'b0;
      len_q  <= '0;
    end else begin
      if (wr_i && is_len && !busy_q) len_q <= wdata_i[15:0];
      if (wr_i && is_stat) begin
        act_q <= wdata_i[ST_ACT];
        ie_q  <= wdata_i[ST_IE];
      end
      if (start_o) begin
        busy_q <= 1'b1;
        prog_q <= wdata_i[ST_PROG];
      end else if (done_i) begin
        busy_q <= 1'b0;
        prog_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_data)      rdata_o = mem[word_i];
    else if (is_len)  rdata_o = {16'h0, len_q};
    else if (is_stat) rdata_o = {act_q, 27'h0, ie_q, 1'b0, prog_q, busy_q};
  end

  assign rd_word = (byte_idx_i[WIN_AW-1:2] < LEN_W) ? mem[byte_idx_i[WIN_AW-1:2]] : 32'h0;
  always_comb begin
    case (byte_idx_i[1:0])
      2'd0:    byte_o = rd_word[7:0];
      2'd1:    byte_o = rd_word[15:8];
      2'd2:    byte_o = rd_word[23:16];
      default: byte_o = rd_word[31:24];
    endcase
  end

  assign busy_o = busy_q;
  assign ie_o   = ie_q;
  assign len_o  = len_q;

  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_i |=> busy_q);
  // R8
  len_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(len_q));
  // R5
  prog_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_q |-> busy_q);
endmodule

// File: rtl/txpp_seq.sv
module txpp_seq import txpp_pkg::*; #(
  parameter int unsigned WIN_AW    = 11,
  parameter int unsigned MAX_FRAME = 1514
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [MAX_BUF-1:0]       start_i,
  input  logic [MAX_BUF-1:0]       load_i,
  input  logic [MAX_BUF-1:0][15:0] len_i,
  input  logic [MAX_BUF-1:0][7:0]  byte_i,
  output logic [WIN_AW-1:0]        byte_idx_o,
  output logic [MAX_BUF-1:0]       done_o,
  output logic [7:0]               txd_o,
  output logic                     tx_valid_o,
  output logic                     tx_last_o,
  input  logic                     tx_ready_i,
  output logic [47:0]              mac_o
);
  localparam logic [15:0]       MAX_LEN  = 16'(MAX_FRAME);
  localparam logic [WIN_AW-1:0] MAC_LAST = WIN_AW'(MAC_BYTES - 1);

  seq_state_e        st_q;
  logic              q_buf [MAX_BUF];
  logic              q_load [MAX_BUF];
  logic              q_head;
  logic [1:0]        q_cnt;
  logic              q_tail, push, pop, fin;
  logic              head_buf, cur_q;
  logic [15:0]       head_len;
  logic [WIN_AW-1:0] eff_len, idx_q, last_q;
  logic [47:0]       mac_q;

  assign push     = |start_i;
  assign q_tail   = q_head ^ (q_cnt == 2'd1);
  assign head_buf = q_buf[q_head];
  assign head_len = len_i[head_buf];
  assign eff_len  = (head_len > MAX_LEN) ? MAX_LEN[WIN_AW-1:0] : head_len[WIN_AW-1:0];

  assign tx_valid_o = st_q == S_SEND;
  assign tx_last_o  = tx_valid_o && idx_q == last_q;
  assign txd_o      = byte_i[cur_q];
  assign fin = (tx_last_o && tx_ready_i) ||
               (st_q == S_LOAD && idx_q == MAC_LAST) || st_q == S_ZERO;
  assign pop    = fin;
  assign done_o = fin ? (MAX_BUF'(1) << cur_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_head <= 1'b0;
      q_cnt  <= '0;
      for (int i = 0; i < MAX_BUF; i++) begin
        q_buf[i]  <= 1'b0;
        q_load[i] <= 1'b0;
      end
    end else begin
      if (push) begin
        q_buf[q_tail]  <= start_i[1];
        q_load[q_tail] <= |(start_i & load_i);
      end
      if (pop) q_head <= ~q_head;
      q_cnt <= q_cnt + {1'b0, push} - {1'b0, pop};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cur_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      mac_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (q_cnt != 2'd0) begin
          cur_q  <= head_buf;
          idx_q  <= '0;
          last_q <= eff_len - WIN_AW'(1);
          if (q_load[q_head])      st_q <= S_LOAD;
          else if (eff_len == '0)  st_q <= S_ZERO;
          else                     st_q <= S_SEND;
        end
        S_SEND: if (tx_ready_i) begin
          if (tx_last_o) st_q <= S_IDLE;
          else           idx_q <= idx_q + WIN_AW'(1);
        end
        S_LOAD: begin
          mac_q[8*(MAC_BYTES-1-int'(idx_q[2:0])) +: 8] <= byte_i[cur_q];
          if (idx_q == MAC_LAST) st_q <= S_IDLE;
          else                   idx_q <= idx_q + WIN_AW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign byte_idx_o = idx_q;
  assign mac_o      = mac_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> q_cnt < 2'(MAX_BUF));
  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(txd_o) && $stable(tx_last_o));
  // R7
  single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
endmodule

// File: rtl/txpp_top.sv
module txpp_top import txpp_pkg::*; #(
  parameter int unsigned NUM_BUF   = 2,
  parameter int unsigned WIN_AW    = 11,
  parameter int unsigned MAX_FRAME = 1514
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIN_AW:2]   bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [7:0]        txd_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  output logic [47:0]       mac_addr_o,
  output logic              irq_o
);
  localparam int unsigned WORD_AW = WIN_AW - 2;
  localparam logic [WORD_AW-1:0] GIE_W = {WORD_AW{1'b1}} - WORD_AW'(1);

  logic [WORD_AW-1:0]       word;
  logic                     win;
  logic [31:0]              bank_rd [MAX_BUF];
  logic [MAX_BUF-1:0]       start, load, busy, ie, done;
  logic [MAX_BUF-1:0][15:0] len;
  logic [MAX_BUF-1:0][7:0]  bytes;
  logic [WIN_AW-1:0]        byte_idx;
  logic                     gie_q, irq_q;
  logic [31:0]              rdata_q;

  assign word = bus_addr_i[WIN_AW-1:2];
  assign win  = bus_addr_i[WIN_AW];

  for (genvar g = 0; g < MAX_BUF; g++) begin : g_buf
    if (g < NUM_BUF) begin : g_on
      txpp_bank #(.WIN_AW(WIN_AW)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (bus_wr_i && win == 1'(g)),
        .word_i    (word),
        .wdata_i   (bus_wdata_i),
        .rdata_o   (bank_rd[g]),
        .byte_idx_i(byte_idx),
        .byte_o    (bytes[g]),
        .done_i    (done[g]),
        .start_o   (start[g]),
        .load_o    (load[g]),
        .busy_o    (busy[g]),
        .ie_o      (ie[g]),
        .len_o     (len[g])
      );
    end else begin : g_off
      assign bank_rd[g] = '0;
      assign bytes[g]   = '0;
      assign start[g]   = 1'b0;
      assign load[g]    = 1'b0;
      assign busy[g]    = 1'b0;
      assign ie[g]      = 1'b0;
      assign len[g]     = '0;
    end
  end

  txpp_seq #(.WIN_AW(WIN_AW), .MAX_FRAME(MAX_FRAME)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .load_i    (load),
    .len_i     (len),
    .byte_i    (bytes),
    .byte_idx_o(byte_idx),
    .done_o    (done),
    .txd_o     (txd_o),
    .tx_valid_o(tx_valid_o),
    .tx_last_o (tx_last_o),
    .tx_ready_i(tx_ready_i),
    .mac_o     (mac_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (bus_wr_i && word == GIE_W) gie_q <= bus_wdata_i[ST_ACT];
      irq_q   <= gie_q && |(done & ie);
      rdata_q <= (word == GIE_W) ? {gie_q, 31'h0} : bank_rd[win];
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  // R6
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(busy & done)));
  // R4
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy[0]) |-> $past(done[0]));
endmodule

// File: tb/tb_txpp_top.sv
module tb_txpp_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:2] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  txd;
  logic        tx_valid, tx_last, irq;
  logic        tx_ready = 1'b1;
  logic [47:0] mac;

  always #5 clk = ~clk;

  txpp_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .txd_o(txd),
    .tx_valid_o(tx_valid), .tx_last_o(tx_last), .tx_ready_i(tx_ready),
    .mac_addr_o(mac), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  int exp_q[$];
  bit fr_irq[$];
  bit irq_track = 1'b1, irq_exp = 1'b0, gie_m = 1'b0;
  int irq_seen = 0;
  int rmode = 1;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 1'b0;
  logic [7:0] prev_d;
  logic prev_l;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = (rmode == 1) ? 1'b1 : (rmode == 0) ? 1'b0 : lfsr[0];
  end

  // cycle-by-cycle stream and interrupt comparison
  always @(negedge clk) begin
    if (rst_ni) begin
      if (irq) irq_seen++;
      if (irq_track) chk(irq == irq_exp, "R6 irq timing", irq, irq_exp);
      irq_exp = 1'b0;
      if (prev_stall) chk(tx_valid && txd == prev_d && tx_last == prev_l, "R10 stall hold",
                          {tx_valid, txd, tx_last}, {1'b1, prev_d, prev_l});
      prev_stall = tx_valid && !tx_ready;
      prev_d = txd;
      prev_l = tx_last;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", txd, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(txd == e[7:0] && tx_last == e[8], "R3 R7 byte/last", {tx_last, txd}, e);
          if (e[8]) irq_exp = fr_irq.pop_front();
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    bus_addr = 10'(a >> 2); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(posedge clk); #1;
    bus_addr = 10'(a >> 2);
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  function automatic int pat(input int seed, input int k);
    return (seed + k * 13) & 255;
  endfunction

  task automatic fill(input int b, input int len, input int seed);
    for (int w = 0; w < (len + 3) / 4; w++)
      wr(b * 2048 + w * 4, {8'(pat(seed, 4*w+3)), 8'(pat(seed, 4*w+2)),
                            8'(pat(seed, 4*w+1)), 8'(pat(seed, 4*w))});
  endtask

  task automatic send(input int b, input int len, input int seed, input bit ie);
    int n;
    fill(b, len, seed);
    wr(b * 2048 + 'h7F4, len);
    n = (len > 1514) ? 1514 : len;
    for (int k = 0; k < n; k++) exp_q.push_back(((k == n - 1) ? 256 : 0) | pat(seed, k));
    if (n > 0) fr_irq.push_back(gie_m && ie);
    wr(b * 2048 + 'h7FC, 32'h8000_0001 | (ie ? 8 : 0));
  endtask

  task automatic wait_idle(input int b);
    int s;
    for (int i = 0; i < 4000; i++) begin
      rd(b * 2048 + 'h7FC, s);
      if (!s[0]) break;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 8000 && exp_q.size() != 0; i++) @(posedge clk);
    wait_idle(0);
    wait_idle(1);
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int d, c;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(!tx_valid && !irq && mac == 48'h0, "R1 outputs", {tx_valid, irq, mac}, 0);
    rd('h7FC, d); chk(d == 0, "R1 status0", d, 0);
    rd('hFFC, d); chk(d == 0, "R1 status1", d, 0);
    rd('h7F8, d); chk(d == 0, "R1 gie", d, 0);

    // R2 map and readback
    wr('h7F4, 'h1234); rd('h7F4, d); chk(d == 'h1234, "R2 length", d, 'h1234);
    wr('h800 + 20, 'hCAFE_F00D); rd('h800 + 20, d); chk(d == 'hCAFEF00D, "R2 data word", d, 'hCAFEF00D);
    wr('hFF8, 'h8000_0000); gie_m = 1'b1;
    rd('h7F8, d); chk(d == 'h8000_0000, "R2 gie alias", d, 'h80000000);

    // R3 R4 basic send with interrupt
    send(0, 9, 5, 1'b1);
    drain();
    rd('h7FC, d); chk(d == 'h8000_0008, "R4 active kept, busy clear", d, 'h80000008);
    wr('h7FC, 'h8); rd('h7FC, d); chk(d == 'h8, "R4 active cleared by write", d, 8);

    // R3 R10 random back-pressure
    rmode = 2;
    send(1, 37, 77, 1'b0);
    drain();

    // R7 ordering with backlog
    rmode = 0;
    send(1, 5, 100, 1'b1);
    send(0, 7, 200, 1'b1);
    rmode = 2;
    drain();
    chk(exp_q.size() == 0, "R7 all drained", exp_q.size(), 0);

    // R8 writes while busy are ignored
    send(0, 40, 33, 1'b0);
    wr('h000, 'hDEAD_BEEF);
    wr('h7F4, 3);
    wr('h7FC, 'h3);
    rd('h7FC, d); chk(d[1:0] == 2'b01, "R8 prog write ignored while busy", d[1:0], 1);
    drain();
    rd('h000, d); chk(d == {8'(pat(33,3)), 8'(pat(33,2)), 8'(pat(33,1)), 8'(pat(33,0))},
                      "R8 data unchanged", d, 0);
    rd('h7F4, d); chk(d == 40, "R8 length unchanged", d, 40);
    rmode = 1;

    // R9 clamp
    send(1, 1600, 9, 1'b0);
    drain();
    chk(exp_q.size() == 0, "R9 clamp drained", exp_q.size(), 0);

    // R9 zero length still completes and interrupts
    irq_track = 1'b0;
    c = irq_seen;
    send(0, 0, 0, 1'b1);
    wait_idle(0);
    repeat (3) @(posedge clk);
    rd('h7FC, d); chk(d[0] == 1'b0, "R9 zero length busy clear", d, 'h80000008);
    chk(irq_seen == c + 1, "R9 zero length irq", irq_seen, c + 1);

    // R5 address load
    c = irq_seen;
    wr('h800, 'h3322_1102);
    wr('h804, 'h0000_5544);
    wr('hFFC, 'h0000_000B);
    wait_idle(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mac == 48'h0211_2233_4455, "R5 mac loaded", mac, 48'h021122334455);
    rd('hFFC, d); chk(d == 'h8, "R5 busy/prog cleared", d, 8);
    chk(irq_seen == c + 1, "R5 load irq", irq_seen, c + 1);
    irq_track = 1'b1;

    // R6 global enable off suppresses interrupt
    wr('h7F8, 0); gie_m = 1'b0;
    send(0, 4, 61, 1'b1);
    drain();
    rd('h7F8, d); chk(d == 0, "R6 gie off", d, 0);

    repeat (5) @(posedge clk);
    finish_up();
  end
endmodule